// File: doc/BRIEF.md
# Redundant reference clock monitor

This block watches two reference clocks and decides which one feeds the downstream clock path. It runs on a feedback clock. Each reference is sampled into that domain and checked by its own activity detector. A detector raises a sticky bad flag for its reference when the sampled level has not changed for too many feedback edges.

While automatic mode is in force, the block moves the selection away from a reference that has just gone bad, but only when the other reference is still good. A manual override hands the choice to the select input and stops automatic switching. The flags keep updating while the override is on. An alarm clear input wipes the flags and the detector history, and while it is held the selection is loaded from the select input. Status outputs report both flags and the reference currently in use.

Top module: `refclk_monitor`

## Requirements
- R1: `ref_in[n]` passes through a two-flop synchronizer. `bad_o[n]` is set once the synchronized level has shown no transition for 3 consecutive feedback edges. A reference that toggles every 1, 2 or 3 feedback cycles is never flagged; one that toggles every 4 or more cycles is flagged.
- R2: A reference that was toggling every cycle and then holds its level has its flag visible after the 6th rising feedback edge that samples the held level, and not after the 5th.
- R3: A set bad flag stays set, even after its reference recovers, until alarm clear or master reset.
- R4: An alarm clear (`alarm_clr_i` = 1 at an edge) clears both flags and both detector histories. A reference that is still stuck is flagged again on the 3rd edge after the release.
- R5: With override and alarm clear both low, when the flag of the selected reference is set and the other flag is clear, `sel_o` changes to the other reference one edge later. This works in both directions. `sel_o` = 0 means `ref_in[0]`.
- R6: When both flags are set and override is low, `sel_o` holds its value and does not toggle.
- R7: While `override_i` = 1, `sel_o` takes the value of `pref_sel_i` at each edge and automatic switching is off. The bad flags keep updating.
- R8: While alarm clear is high, `sel_o` takes the value of `pref_sel_i`. After release, automatic operation continues from that choice.
- R9: Synchronous active-low reset `rst_n` clears the flags, counters and synchronizers, and sets `sel_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fb | input | 1 | Feedback clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low master reset |
| ref_in | input | 2 | Reference clock inputs, bit n is reference n |
| pref_sel_i | input | 1 | Preferred reference for override and alarm clear |
| override_i | input | 1 | 1 = selection follows `pref_sel_i`, no auto switch |
| alarm_clr_i | input | 1 | Clears bad flags and detector histories |
| bad_o | output | 2 | Sticky bad flags, bit n for reference n |
| sel_o | output | 1 | Reference currently selected |

## Verification
Assertions check the following on every cycle: flags rise only when the stuck counter reaches its limit, flags persist until a clear, and a clear empties them. They also check the selection rules: the switch away from a bad selected reference, the hold when both references are bad, and loading of the preferred input under override or clear. Only the bench scenarios can show the end-to-end latency from a frozen reference to its flag and to the switchover. The same holds for the exact toggle period that separates a healthy reference from a stuck one, and for re-flagging after a clear while the reference is still stuck.

// File: rtl/refmon_pkg.sv
// Package: shared constants and helpers for the reference clock monitor.
// Assumes exactly two references; selection index is one bit wide.
package refmon_pkg;
    localparam int unsigned NUM_REFS = 2;

    // Index of the reference that is not currently selected.
    function automatic logic other_ref(input logic idx);
        return ~idx;
    endfunction
endpackage

// File: rtl/refmon_sync.sv
// Module: refmon_sync
// Brings one asynchronous level into the feedback clock domain through a
// chain of STAGES flops. Assumes STAGES >= 2; resets the chain to zero.
module refmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level along the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/refmon_stuck_det.sv
// Module: refmon_stuck_det
// Counts feedback edges without a level change on a synchronized reference.
// Raises a sticky bad flag when the count reaches LIMIT. A clear empties the
// counter and flag. Assumes lvl_i is already synchronous to clk.
module refmon_stuck_det #(
    parameter int unsigned LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic lvl_i,
    output logic bad_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          changed;
    logic          hit;

    // Next count: zero on a transition, otherwise saturating increment.
    always_comb begin
        changed = (lvl_i != prev_q);
        if (changed)          cnt_d = '0;
        else if (cnt_q == LIM) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
        hit = (cnt_d == LIM);
    end

    // Hold last level, count, and latch the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
            bad_o  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (clr_i) begin
                cnt_q <= '0;
                bad_o <= 1'b0;
            end else begin
                cnt_q <= cnt_d;
                bad_o <= bad_o | hit;
            end
        end
    end

    // R1: a flag only rises from a counter one short of the limit.
    a_r1_rise_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_o) |-> ($past(cnt_q) == LIM - 1'b1));
    // R3: a flag stays set unless a clear is applied.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_o && !clr_i) |=> bad_o);
    // R4: a clear leaves the flag low and the counter empty.
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!bad_o && cnt_q == '0));
endmodule

// File: rtl/refmon_select.sv
// Module: refmon_select
// Chooses the active reference from the two bad flags. Under override or
// alarm clear it loads the preferred input. Otherwise it moves away from a
// bad selection when the other side is good, and holds when both are bad.
module refmon_select
    import refmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] bad_i,
    input  logic                pref_i,
    input  logic                ovr_i,
    input  logic                clr_i,
    output logic                sel_o
);
    logic sel_d;
    logic alt;

    // Selection rule: forced load, fault switch, or hold.
    always_comb begin
        alt = other_ref(sel_o);
        if (ovr_i || clr_i)                 sel_d = pref_i;
        else if (bad_i[sel_o] && !bad_i[alt]) sel_d = alt;
        else                                sel_d = sel_o;
    end

    // Register the selection; reset picks reference 0.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_o <= 1'b0;
        else        sel_o <= sel_d;
    end

    // R5: auto mode leaves a bad selection when the other side is good.
    a_r5_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_i && !clr_i && bad_i[sel_o] && !bad_i[~sel_o])
        |=> (sel_o != $past(sel_o)));
    // R6: both bad in auto mode keeps the selection still.
    a_r6_hold_both_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_i && !clr_i && (&bad_i)) |=> $stable(sel_o));
    // R7 / R8: override or clear loads the preferred input.
    a_r7_force_pref: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_i || clr_i) |=> (sel_o == $past(pref_i)));
endmodule

// File: rtl/refclk_monitor.sv
// Module: refclk_monitor (top)
// Two synchronized activity detectors and one selector, all on the feedback
// clock. Assumes the references are asynchronous and the feedback clock
// runs faster than twice the highest expected idle period resolution.
module refclk_monitor
    import refmon_pkg::*;
#(
    parameter int unsigned STUCK_EDGES = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_fb,
    input  logic       rst_n,
    input  logic [1:0] ref_in,
    input  logic       pref_sel_i,
    input  logic       override_i,
    input  logic       alarm_clr_i,
    output logic [1:0] bad_o,
    output logic       sel_o
);
    logic [NUM_REFS-1:0] lvl_sync;

    // One synchronizer and detector per reference.
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
        refmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk_fb),
            .rst_n (rst_n),
            .d_i   (ref_in[g]),
            .q_o   (lvl_sync[g])
        );
        refmon_stuck_det #(.LIMIT(STUCK_EDGES)) u_det (
            .clk   (clk_fb),
            .rst_n (rst_n),
            .clr_i (alarm_clr_i),
            .lvl_i (lvl_sync[g]),
            .bad_o (bad_o[g])
        );
    end

    refmon_select u_sel (
        .clk    (clk_fb),
        .rst_n  (rst_n),
        .bad_i  (bad_o),
        .pref_i (pref_sel_i),
        .ovr_i  (override_i),
        .clr_i  (alarm_clr_i),
        .sel_o  (sel_o)
    );
endmodule

// File: tb/refclk_monitor_tb.sv
module refclk_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_in = 2'b00;
    logic       pref = 1'b0;
    logic       ovr = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] bad;
    logic       sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int hp0 = 1, hp1 = 1;   // toggle half-period in cycles, 0 = frozen
    int c0 = 0, c1 = 0;

    always #4 clk = ~clk;   // 125 MHz

    refclk_monitor u_dut (
        .clk_fb(clk), .rst_n(rst_n), .ref_in(ref_in), .pref_sel_i(pref),
        .override_i(ovr), .alarm_clr_i(clr), .bad_o(bad), .sel_o(sel)
    );

    // Reference generators, updated on the falling edge.
    always @(negedge clk) begin
        if (hp0 != 0) begin c0++; if (c0 >= hp0) begin c0 = 0; ref_in[0] = ~ref_in[0]; end end
        if (hp1 != 0) begin c1++; if (c1 >= hp1) begin c1 = 0; ref_in[1] = ~ref_in[1]; end end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic alarm_pulse();
        clr = 1'b1; step(1); clr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic s;
        step(4);
        chk("R9 reset flags", bad, 2'b00);
        chk("R9 reset sel", {1'b0, sel}, 2'b00);
        rst_n = 1'b1;

        // R1 sweep: ref0 half-period 1..6 with ref1 healthy.
        for (int h = 1; h <= 6; h++) begin
            hp0 = h; hp1 = 1; pref = 1'b0;
            alarm_pulse();
            step(40);
            chk($sformatf("R1 ref0 period %0d flags", h), bad, {1'b0, (h >= 4)});
            chk($sformatf("R5 ref0 period %0d sel", h), {1'b0, sel}, {1'b0, (h >= 4)});
        end
        // R1 sweep: ref1 half-period 1..6 with ref0 healthy.
        for (int h = 1; h <= 6; h++) begin
            hp0 = 1; hp1 = h; pref = 1'b0;
            alarm_pulse();
            step(40);
            chk($sformatf("R1 ref1 period %0d flags", h), bad, {(h >= 4), 1'b0});
            chk($sformatf("R6 ref1 period %0d sel", h), {1'b0, sel}, 2'b00);
        end

        // R2 exact latency and R5 switch 0 -> 1.
        hp0 = 1; hp1 = 1; pref = 1'b0;
        alarm_pulse();
        step(10);
        chk("R8 sel after clear", {1'b0, sel}, 2'b00);
        hp0 = 0;
        step(5);
        chk("R2 not yet flagged", bad, 2'b00);
        step(1);
        chk("R2 flagged on 6th edge", bad, 2'b01);
        chk("R5 sel before switch", {1'b0, sel}, 2'b00);
        step(1);
        chk("R5 switched to ref1", {1'b0, sel}, 2'b01);

        // R3 sticky after recovery.
        hp0 = 1;
        step(20);
        chk("R3 flag sticky", bad, 2'b01);
        chk("R3 sel stays", {1'b0, sel}, 2'b01);

        // R4/R8 clear with healthy ref returns to preferred.
        alarm_pulse();
        step(10);
        chk("R4 flags cleared", bad, 2'b00);
        chk("R8 sel back to pref", {1'b0, sel}, 2'b00);

        // R4 re-flag after clear while still stuck.
        hp0 = 0;
        step(20);
        chk("R4 stuck flagged", bad, 2'b01);
        clr = 1'b1; step(1); clr = 1'b0;
        chk("R4 clear edge flags", bad, 2'b00);
        chk("R8 clear edge sel", {1'b0, sel}, 2'b00);
        step(2);
        chk("R4 not re-flagged at 2", bad, 2'b00);
        step(1);
        chk("R4 re-flagged at 3", bad, 2'b01);
        step(1);
        chk("R5 switched again", {1'b0, sel}, 2'b01);

        // R6 both bad: no toggling.
        hp1 = 0;
        step(10);
        chk("R6 both flagged", bad, 2'b11);
        for (int i = 0; i < 10; i++) begin
            step(1);
            chk("R6 sel held", {1'b0, sel}, 2'b01);
        end

        // R7 override follows pref.
        ovr = 1'b1; pref = 1'b0; step(1);
        chk("R7 sel follows pref 0", {1'b0, sel}, 2'b00);
        pref = 1'b1; step(1);
        chk("R7 sel follows pref 1", {1'b0, sel}, 2'b01);
        alarm_pulse();
        step(10);
        chk("R7 flags update under override", bad, 2'b11);
        chk("R7 no auto switch", {1'b0, sel}, 2'b01);
        pref = 1'b0; hp1 = 1; alarm_pulse(); step(10);
        chk("R7 ref0 bad, sel pinned", {1'b0, sel}, 2'b00);
        chk("R7 flags", bad, 2'b01);

        // R5 switch 1 -> 0.
        ovr = 1'b0; pref = 1'b1; hp0 = 1; hp1 = 1;
        alarm_pulse(); step(10);
        chk("R8 pref 1 after clear", {1'b0, sel}, 2'b01);
        hp1 = 0; step(12);
        chk("R5 ref1 flagged", bad, 2'b10);
        chk("R5 switched to ref0", {1'b0, sel}, 2'b00);

        // R9 master reset mid-run.
        s = sel;
        rst_n = 1'b0; step(1);
        chk("R9 mid reset flags", bad, 2'b00);
        chk("R9 mid reset sel", {1'b0, sel}, 2'b00);
        rst_n = 1'b1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule